// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block sits between the digital controls of a DC motor full bridge and its four gate drivers. From a direction input, an enable input (normally chopped by an external PWM source), a decay-mode select and an active-high awake input, it decides for each of the two bridge legs whether the high-side switch, the low-side switch or neither is on. It inserts a dead time on every leg transition, so the two switches of a leg never conduct together.

Outputs are held off after reset until supplies have settled, held off again after the bridge wakes from sleep so the gate pump can recover, and held off while any of four fault flags is raised. In fast-decay recirculation the bridge is opened entirely once a current-near-zero flag is seen, so the winding current cannot reverse. Every control and fault input is brought into the clock domain through a two-flop synchroniser. A two-bit state output reports whether the bridge is running, asleep, holding off or faulted.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With awake high, no fault and hold-off over, enable high drives leg A high and leg B low when dir is 1, and leg A low and leg B high when dir is 0, whatever the decay-mode input.
- R2: With enable low and slow-decay high, both legs drive their low-side switch, whatever dir is.
- R3: With enable low and slow-decay low (fast decay), dir=1 gives leg A low and leg B high, and dir=0 gives leg A high and leg B low.
- R4: In fast decay, once the current-near-zero flag is seen, all four gate commands go low and stay low, even after the flag drops, until the bridge leaves fast decay.
- R5: Awake low turns all four gate commands off and reports state 1 (asleep), overriding every other input including faults.
- R6: A leg's high-side and low-side commands are never both high, the two high-side commands are never both high, and after either switch of a leg turns off, neither switch of that leg turns on for at least DEAD_CYC clock cycles.
- R7: While any of the over-temperature, pump-low, regulator-low or supply-low flags is high, all gate commands are off and the state output is 3 (fault); normal drive resumes once every flag clears.
- R8: After reset the state output is 2 (hold-off) with all commands off, and stays so for PWRUP_CYC cycles before the state becomes 0 (running).
- R9: After awake rises, the state stays 2 (hold-off) with all commands off for WAKE_CYC cycles before running resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_i | input | 1 | Direction select |
| drive_en_i | input | 1 | Drive enable (PWM chop input) |
| slow_decay_i | input | 1 | 1 = slow-decay brake when enable is low, 0 = fast decay |
| awake_i | input | 1 | 1 = operate, 0 = sleep |
| ovt_i | input | 1 | Over-temperature fault flag |
| pump_low_i | input | 1 | Gate pump supply low flag |
| reg_low_i | input | 1 | Low-side regulator supply low flag |
| supply_low_i | input | 1 | Load supply undervoltage flag |
| izero_i | input | 1 | Winding current near zero |
| a_hi_o | output | 1 | Leg A high-side gate command |
| a_lo_o | output | 1 | Leg A low-side gate command |
| b_hi_o | output | 1 | Leg B high-side gate command |
| b_lo_o | output | 1 | Leg B low-side gate command |
| state_o | output | 2 | 0 running, 1 asleep, 2 hold-off, 3 fault |

## Verification
The assertions assume the inputs are quasi-static relative to the clock, so that each change is seen once through the synchroniser and the state output leads the gate commands by exactly one register. The dead-time property assumes reset clears the gate commands, so the first turn-on after reset is treated as already separated. The stimulus holds every input steady for many tens of cycles per step, changes inputs only on the falling clock edge, and toggles one control at a time so each transition passes through the full dead-time window before the next.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_HOLD  = 2'd2,
      ST_FAULT = 2'd3
   } bridge_state_e;

   typedef enum logic [1:0] {
      LEG_OFF  = 2'd0,
      LEG_HIGH = 2'd1,
      LEG_LOW  = 2'd2
   } leg_cmd_e;

   localparam int unsigned NUM_LEGS   = 2;
   localparam int unsigned NUM_FAULTS = 4;

   // bundle of synchronised control inputs
   typedef struct packed {
      logic                  awake;
      logic                  en;
      logic                  slow;
      logic                  dir;
      logic                  izero;
      logic [NUM_FAULTS-1:0] fault;
   } ctl_s;

   localparam int unsigned CTL_W = $bits(ctl_s);

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
   parameter int unsigned            WIDTH   = 1,
   parameter int unsigned            STAGES  = 2,
   parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hbg_sequencer.sv
module hbg_sequencer
   import hbg_pkg::*;
#(
   parameter int unsigned PWRUP_CYC = 40000,
   parameter int unsigned WAKE_CYC  = 200000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          awake_i,
   input  logic          fault_i,
   output bridge_state_e state_o
);

   localparam int unsigned LIM = (PWRUP_CYC > WAKE_CYC) ? PWRUP_CYC : WAKE_CYC;
   localparam int unsigned TW  = $clog2(LIM + 1);
   localparam logic [TW-1:0] PWRUP_LD = TW'(PWRUP_CYC);
   localparam logic [TW-1:0] WAKE_LD  = TW'(WAKE_CYC);

   logic [TW-1:0] hold_q;
   bridge_state_e state_q, state_d;

   // hold-off timer: preset at reset, reloaded while asleep, counts down while awake
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hold_q <= PWRUP_LD;
      else if (!awake_i)       hold_q <= WAKE_LD;
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
   end

   always_comb begin
      if (!awake_i)           state_d = ST_SLEEP;
      else if (fault_i)       state_d = ST_FAULT;
      else if (hold_q != '0)  state_d = ST_HOLD;
      else                    state_d = ST_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_HOLD;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
   import hbg_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  bridge_state_e state_i,
   input  logic          en_i,
   input  logic          slow_i,
   input  logic          dir_i,
   input  logic          izero_i,
   output leg_cmd_e      tgt_a_o,
   output leg_cmd_e      tgt_b_o
);

   logic fast_run;
   logic zlatch_q;

   assign fast_run = (state_i == ST_RUN) && !en_i && !slow_i;

   // once the current is seen near zero in fast decay, keep the bridge open
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zlatch_q <= 1'b0;
      else        zlatch_q <= fast_run && (zlatch_q || izero_i);
   end

   always_comb begin
      tgt_a_o = LEG_OFF;
      tgt_b_o = LEG_OFF;
      if (state_i == ST_RUN) begin
         if (en_i) begin
            tgt_a_o = dir_i ? LEG_HIGH : LEG_LOW;
            tgt_b_o = dir_i ? LEG_LOW  : LEG_HIGH;
         end else if (slow_i) begin
            tgt_a_o = LEG_LOW;
            tgt_b_o = LEG_LOW;
         end else if (!(zlatch_q || izero_i)) begin
            tgt_a_o = dir_i ? LEG_LOW  : LEG_HIGH;
            tgt_b_o = dir_i ? LEG_HIGH : LEG_LOW;
         end
      end
   end

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
   import hbg_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 100
) (
   input  logic     clk,
   input  logic     rst_n,
   input  leg_cmd_e tgt_i,
   output logic     hi_o,
   output logic     lo_o
);

   localparam int unsigned    DW      = $clog2(DEAD_CYC + 1);
   localparam logic [DW-1:0]  DEAD_LD = DW'(DEAD_CYC);

   logic          want_hi, want_lo, drop;
   logic          hi_q, lo_q;
   logic [DW-1:0] dead_q;

   assign want_hi = (tgt_i == LEG_HIGH);
   assign want_lo = (tgt_i == LEG_LOW);
   // a conducting switch that is no longer wanted must open first
   assign drop    = (hi_q && !want_hi) || (lo_q && !want_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= 1'b0;
         lo_q   <= 1'b0;
         dead_q <= '0;
      end else if (drop) begin
         hi_q   <= 1'b0;
         lo_q   <= 1'b0;
         dead_q <= DEAD_LD;
      end else if (dead_q != '0) begin
         dead_q <= dead_q - 1'b1;
      end else begin
         hi_q   <= want_hi;
         lo_q   <= want_lo;
      end
   end

   assign hi_o = hi_q;
   assign lo_o = lo_q;

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
   import hbg_pkg::*;
#(
   parameter int unsigned DEAD_CYC    = 100,
   parameter int unsigned PWRUP_CYC   = 40000,
   parameter int unsigned WAKE_CYC    = 200000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dir_i,
   input  logic       drive_en_i,
   input  logic       slow_decay_i,
   input  logic       awake_i,
   input  logic       ovt_i,
   input  logic       pump_low_i,
   input  logic       reg_low_i,
   input  logic       supply_low_i,
   input  logic       izero_i,
   output logic       a_hi_o,
   output logic       a_lo_o,
   output logic       b_hi_o,
   output logic       b_lo_o,
   output logic [1:0] state_o
);

   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("hbridge_gate_ctrl: DEAD_CYC must be at least 1");
      end
      if (PWRUP_CYC < 1) begin : g_bad_pwrup
         $error("hbridge_gate_ctrl: PWRUP_CYC must be at least 1");
      end
      if (WAKE_CYC < 1) begin : g_bad_wake
         $error("hbridge_gate_ctrl: WAKE_CYC must be at least 1");
      end
   endgenerate

   // awake resets high so reset itself does not look like a wake event
   localparam ctl_s CTL_RST = '{awake: 1'b1, default: '0};

   ctl_s          raw, syn;
   bridge_state_e state;
   leg_cmd_e      tgt [NUM_LEGS];
   logic [NUM_LEGS-1:0] leg_hi, leg_lo;

   assign raw.awake = awake_i;
   assign raw.en    = drive_en_i;
   assign raw.slow  = slow_decay_i;
   assign raw.dir   = dir_i;
   assign raw.izero = izero_i;
   assign raw.fault = {supply_low_i, reg_low_i, pump_low_i, ovt_i};

   hbg_sync #(
      .WIDTH   (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTL_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (syn)
   );

   hbg_sequencer #(
      .PWRUP_CYC (PWRUP_CYC),
      .WAKE_CYC  (WAKE_CYC)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .awake_i (syn.awake),
      .fault_i (|syn.fault),
      .state_o (state)
   );

   hbg_decode u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (state),
      .en_i    (syn.en),
      .slow_i  (syn.slow),
      .dir_i   (syn.dir),
      .izero_i (syn.izero),
      .tgt_a_o (tgt[0]),
      .tgt_b_o (tgt[1])
   );

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      hbg_leg #(
         .DEAD_CYC (DEAD_CYC)
      ) u_leg (
         .clk   (clk),
         .rst_n (rst_n),
         .tgt_i (tgt[g]),
         .hi_o  (leg_hi[g]),
         .lo_o  (leg_lo[g])
      );
   end

   assign a_hi_o  = leg_hi[0];
   assign a_lo_o  = leg_lo[0];
   assign b_hi_o  = leg_hi[1];
   assign b_lo_o  = leg_lo[1];
   assign state_o = state;

endmodule

// File: rtl/hbridge_gate_ctrl_chk.sv
module hbridge_gate_ctrl_chk #(
   parameter int unsigned DEAD_CYC = 100
) (
   input logic       clk,
   input logic       rst_n,
   input logic       a_hi_o,
   input logic       a_lo_o,
   input logic       b_hi_o,
   input logic       b_lo_o,
   input logic [1:0] state_o
);

   localparam int unsigned   GW     = $clog2(DEAD_CYC + 1);
   localparam logic [GW-1:0] GAP_OK = GW'(DEAD_CYC);

   logic          a_on, b_on, a_prev, b_prev, all_off;
   logic [GW-1:0] a_gap, b_gap;

   assign a_on    = a_hi_o || a_lo_o;
   assign b_on    = b_hi_o || b_lo_o;
   assign all_off = !a_on && !b_on;

   // count off cycles of each leg, saturating at the required dead time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_prev <= 1'b0;
         b_prev <= 1'b0;
         a_gap  <= GAP_OK;
         b_gap  <= GAP_OK;
      end else begin
         a_prev <= a_on;
         b_prev <= b_on;
         if (a_on)                a_gap <= '0;
         else if (a_gap < GAP_OK) a_gap <= a_gap + 1'b1;
         if (b_on)                b_gap <= '0;
         else if (b_gap < GAP_OK) b_gap <= b_gap + 1'b1;
      end
   end

   p_no_shoot_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_hi_o && a_lo_o));
   p_no_shoot_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_hi_o && b_lo_o));
   p_highs_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_hi_o && b_hi_o));
   p_dead_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (a_on && !a_prev) |-> (a_gap >= GAP_OK));
   p_dead_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (b_on && !b_prev) |-> (b_gap >= GAP_OK));
   p_sleep_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1) |=> all_off);
   p_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3) |=> all_off);
   p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2) |=> all_off);
   p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1) |=> (state_o != 2'd0));

endmodule

bind hbridge_gate_ctrl hbridge_gate_ctrl_chk #(
   .DEAD_CYC (DEAD_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .a_hi_o  (a_hi_o),
   .a_lo_o  (a_lo_o),
   .b_hi_o  (b_hi_o),
   .b_lo_o  (b_lo_o),
   .state_o (state_o)
);

// File: tb/hbridge_gate_ctrl_test.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_test;

   localparam int unsigned DEAD  = 8;
   localparam int unsigned PWRUP = 50;
   localparam int unsigned WAKE  = 120;
   localparam int unsigned WDOG  = 100000;

   logic clk = 1'b0;
   logic rst_n;
   logic dir, en, slow, awake, izero;
   logic [3:0] flt;
   logic a_hi, a_lo, b_hi, b_lo;
   logic [1:0] st;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   hbridge_gate_ctrl #(
      .DEAD_CYC  (DEAD),
      .PWRUP_CYC (PWRUP),
      .WAKE_CYC  (WAKE)
   ) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .dir_i        (dir),
      .drive_en_i   (en),
      .slow_decay_i (slow),
      .awake_i      (awake),
      .ovt_i        (flt[0]),
      .pump_low_i   (flt[1]),
      .reg_low_i    (flt[2]),
      .supply_low_i (flt[3]),
      .izero_i      (izero),
      .a_hi_o       (a_hi),
      .a_lo_o       (a_lo),
      .b_hi_o       (b_hi),
      .b_lo_o       (b_lo),
      .state_o      (st)
   );

   typedef struct packed {
      logic [3:0] req;
      logic       en, slow, dir, izero;
      logic [5:0] exp;   // {a_hi, a_lo, b_hi, b_lo, state}
   } vec_t;

   localparam vec_t VEC [12] = '{
      '{4'd1, 1'b1, 1'b0, 1'b1, 1'b0, 6'b1001_00},  // R1 forward
      '{4'd1, 1'b1, 1'b1, 1'b1, 1'b0, 6'b1001_00},  // R1 mode ignored
      '{4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 6'b0110_00},  // R1 reverse
      '{4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b0110_00},  // R1 reverse, other mode
      '{4'd2, 1'b0, 1'b1, 1'b1, 1'b0, 6'b0101_00},  // R2 brake dir=1
      '{4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 6'b0101_00},  // R2 brake dir=0
      '{4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 6'b0110_00},  // R3 fast dir=1
      '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 6'b1001_00},  // R3 fast dir=0
      '{4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 6'b0000_00},  // R4 zero current opens bridge
      '{4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 6'b0000_00},  // R4 stays open after flag drops
      '{4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 6'b1001_00},  // R4 leaving fast decay clears
      '{4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 6'b0110_00}   // R4 fresh fast decay drives again
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic [5:0] act, input logic [5:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] outs();
      return {a_hi, a_lo, b_hi, b_lo, st};
   endfunction

   initial begin
      rst_n = 1'b0; awake = 1'b1; en = 1'b1; dir = 1'b1; slow = 1'b0;
      izero = 1'b0; flt = 4'b0;
      tick(5);
      rst_n = 1'b1;
      tick(1);
      chk(outs(), 6'b0000_10, "R8 reset state");
      tick(PWRUP - 15);
      chk(outs(), 6'b0000_10, "R8 still holding off");
      tick(40);
      chk(outs(), 6'b1001_00, "R8 running after hold-off");

      for (int i = 0; i < 12; i++) begin
         en = VEC[i].en; slow = VEC[i].slow; dir = VEC[i].dir; izero = VEC[i].izero;
         tick(40);
         chk(outs(), VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
      end

      // R6 dead time on a direction reversal
      en = 1'b1; slow = 1'b0; dir = 1'b1; izero = 1'b0;
      tick(40);
      dir = 1'b0;
      begin
         int off_a = 0;
         for (int k = 0; k < 40; k++) begin
            tick(1);
            if (!a_hi && !a_lo) off_a++;
         end
         chk({5'b0, (off_a >= DEAD && off_a <= DEAD + 1)}, 6'd1,
             $sformatf("R6 leg A off cycles %0d", off_a));
      end
      chk(outs(), 6'b0110_00, "R6 reversed after dead time");

      // R5 sleep, overriding a fault
      awake = 1'b0;
      tick(8);
      chk(outs(), 6'b0000_01, "R5 asleep");
      flt[0] = 1'b1;
      tick(8);
      chk(outs(), 6'b0000_01, "R5 sleep overrides fault");
      flt[0] = 1'b0;
      tick(4);

      // R9 wake hold-off
      awake = 1'b1;
      tick(10);
      chk(outs(), 6'b0000_10, "R9 hold-off after wake");
      tick(WAKE - 20);
      chk(outs(), 6'b0000_10, "R9 hold-off near end");
      tick(40);
      chk(outs(), 6'b0110_00, "R9 running after wake");

      // R7 each fault flag
      for (int f = 0; f < 4; f++) begin
         flt = 4'b1 << f;
         tick(8);
         chk(outs(), 6'b0000_11, $sformatf("R7 fault flag %0d", f));
         flt = 4'b0;
         tick(40);
         chk(outs(), 6'b0110_00, $sformatf("R7 recovered from flag %0d", f));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

endmodule